// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for every architectural floating-point register, the committed value and the tag of the reservation station that will produce that register's next value. A tag of zero means that no producer is pending. When an instruction issues, the table reports either a ready value or a producer tag for each of its two source registers. In the same cycle it records the newly allocated station's tag as the producer of the destination register. A later writer simply overwrites the earlier tag, so a write-after-write pair never needs a stall.

Functional units announce results on a shared result bus. The bus carries a producer tag and a data word. Every register whose recorded producer equals that tag takes the data and drops back to "no producer". A broadcast whose tag no longer matches leaves the register alone, because a younger instruction already owns it.

Source lookups are combinational. A lookup that coincides with a matching broadcast sees the broadcast data directly.

Top module: `rename_table`

## Requirements
- R1: After reset every register reads as value 0 with tag 0.
- R2: A source register whose recorded producer is 0 returns its stored value on the value output, and 0 on the tag output, in the same cycle.
- R3: A source register with a nonzero recorded producer returns that tag on the tag output and 0 on the value output.
- R4: When iss_valid is high at a clock edge, the destination register's recorded producer becomes iss_tag from the next cycle on.
- R5: A broadcast (cdb_valid high, cdb_tag nonzero) writes cdb_data into every register whose recorded producer equals cdb_tag, and clears that producer to 0 at the same edge.
- R6: A broadcast whose tag differs from a register's recorded producer leaves that register's value and producer unchanged (stale broadcast).
- R7: If issue renames a register at the same edge that the register's current producer broadcasts, the register's producer after that edge is iss_tag.
- R8: A source lookup made while a matching broadcast is on the bus returns cdb_data with tag 0 (bypass).
- R9: A broadcast with cdb_tag equal to 0 changes nothing and bypasses nothing.
- R10: When several registers record the same producer, a single broadcast of that tag updates all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Tag of the allocated station (nonzero) |
| src_a | input | 4 | First source register index |
| src_b | input | 4 | Second source register index |
| a_val | output | 64 | Ready value of src_a, 0 when pending |
| a_tag | output | 4 | Producer tag of src_a, 0 when ready |
| b_val | output | 64 | Ready value of src_b, 0 when pending |
| b_tag | output | 4 | Producer tag of src_b, 0 when ready |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | 4 | Tag of the producing station |
| cdb_data | input | 64 | Result data |

## Verification
The bench uses the default parameters: 16 registers, 64-bit data and 4-bit tags. With only 15 usable tags spread over 16 registers, random issue streams often give one tag to several registers and often rename a register while its old producer is still outstanding. Stale broadcasts, multi-register matches and same-edge issue/broadcast collisions therefore occur often in the random phase, on top of the directed cases for each of them.

// File: rtl/rename_table.sv
module rename_table #(
  parameter int NREG = 16,
  parameter int DW   = 64,
  parameter int TW   = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [AW-1:0] iss_dst,
  input  logic [TW-1:0] iss_tag,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  output logic [DW-1:0] a_val,
  output logic [TW-1:0] a_tag,
  output logic [DW-1:0] b_val,
  output logic [TW-1:0] b_tag,
  input  logic          cdb_valid,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_data
);

  logic [TW-1:0] map_q [NREG];
  logic [DW-1:0] val_q [NREG];

  wire bus_live = cdb_valid && (cdb_tag != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        map_q[r] <= '0;
        val_q[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (bus_live && map_q[r] == cdb_tag) begin
          val_q[r] <= cdb_data;
          map_q[r] <= '0;
        end
        if (iss_valid && iss_dst == AW'(r))
          map_q[r] <= iss_tag;
      end
    end
  end

  wire a_byp = bus_live && (map_q[src_a] == cdb_tag);
  wire b_byp = bus_live && (map_q[src_b] == cdb_tag);

  assign a_tag = a_byp ? '0 : map_q[src_a];
  assign b_tag = b_byp ? '0 : map_q[src_b];
  assign a_val = a_byp ? cdb_data : (map_q[src_a] == '0 ? val_q[src_a] : '0);
  assign b_val = b_byp ? cdb_data : (map_q[src_b] == '0 ? val_q[src_b] : '0);

  // R3
  pending_hides_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_tag != '0) |-> (a_val == '0));

  // R4
  issue_rename_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> (map_q[$past(iss_dst)] == $past(iss_tag)));

  // R5
  bcast_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_live && map_q[src_a] == cdb_tag && !(iss_valid && iss_dst == src_a))
    |=> (map_q[$past(src_a)] == '0 && val_q[$past(src_a)] == $past(cdb_data)));

  // R6
  stale_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && map_q[src_a] != cdb_tag && !(iss_valid && iss_dst == src_a))
    |=> (map_q[$past(src_a)] == $past(map_q[src_a]) &&
         val_q[$past(src_a)] == $past(val_q[src_a])));

  // R7
  issue_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && bus_live && map_q[iss_dst] == cdb_tag)
    |=> (map_q[$past(iss_dst)] == $past(iss_tag)));

endmodule

// File: tb/rename_table_tb.sv
`timescale 1ns/1ps
module rename_table_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        iss_valid = 0;
  logic [3:0]  iss_dst = 0, iss_tag = 0, src_a = 0, src_b = 0;
  logic        cdb_valid = 0;
  logic [3:0]  cdb_tag = 0;
  logic [63:0] cdb_data = 0;
  logic [63:0] a_val, b_val;
  logic [3:0]  a_tag, b_tag;

  int total = 0, bad = 0;
  logic [3:0]  m [16];
  logic [63:0] v [16];

  always #2.5 clk = ~clk;

  rename_table u_dut (.clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
    .iss_dst(iss_dst), .iss_tag(iss_tag), .src_a(src_a), .src_b(src_b),
    .a_val(a_val), .a_tag(a_tag), .b_val(b_val), .b_tag(b_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data));

  task automatic check(input bit ok, input string req, input logic [63:0] act_v,
                       input logic [3:0] act_t, input logic [63:0] exp_v,
                       input logic [3:0] exp_t);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got val=%h tag=%0d, expected val=%h tag=%0d",
               req, act_v, act_t, exp_v, exp_t);
    end
  endtask

  task automatic expect_src(input logic [3:0] s, input logic [63:0] av,
                            input logic [3:0] at, input string force_req);
    logic [63:0] ev;
    logic [3:0]  et;
    string req;
    if (cdb_valid && cdb_tag != 0 && m[s] == cdb_tag) begin
      ev = cdb_data; et = 0; req = "R8";
    end else if (m[s] == 0) begin
      ev = v[s]; et = 0; req = "R2";
    end else begin
      ev = 0; et = m[s]; req = "R3";
    end
    if (force_req != "") req = force_req;
    check(av == ev && at == et, req, av, at, ev, et);
  endtask

  task automatic step(input bit iv, input logic [3:0] dst, input logic [3:0] tg,
                      input bit cv, input logic [3:0] ct, input logic [63:0] cd,
                      input logic [3:0] sa, input logic [3:0] sb, input string req);
    iss_valid = iv; iss_dst = dst; iss_tag = tg;
    cdb_valid = cv; cdb_tag = ct; cdb_data = cd;
    src_a = sa; src_b = sb;
    #1;
    expect_src(sa, a_val, a_tag, req);
    expect_src(sb, b_val, b_tag, req);
    @(posedge clk);
    for (int r = 0; r < 16; r++)
      if (cv && ct != 0 && m[r] == ct) begin v[r] = cd; m[r] = 0; end
    if (iv) m[dst] = tg;
    #1;
  endtask

  task automatic idle_look(input logic [3:0] sa, input logic [3:0] sb, input string req);
    step(0, 0, 0, 0, 0, 0, sa, sb, req);
  endtask

  initial begin
    for (int r = 0; r < 16; r++) begin m[r] = 0; v[r] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state of every register
    for (int r = 0; r < 16; r += 2) idle_look(r[3:0], r[3:0] + 4'd1, "R1");
    // R4: rename r3 to tag 5
    step(1, 3, 5, 0, 0, 0, 0, 0, "");
    idle_look(3, 3, "R4");
    // R8 bypass then R5 writeback
    step(0, 0, 0, 1, 5, 64'hA5A5_0000_1111_2222, 3, 1, "R8");
    idle_look(3, 2, "R5");
    // R6 stale broadcast
    step(1, 4, 6, 0, 0, 0, 0, 0, "");
    step(1, 4, 7, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 1, 6, 64'hDEAD, 4, 4, "R6");
    idle_look(4, 4, "R6");
    step(0, 0, 0, 1, 7, 64'hBEEF, 0, 0, "");
    idle_look(4, 4, "R5");
    // R7 same-edge issue and broadcast of old producer
    step(1, 5, 8, 0, 0, 0, 0, 0, "");
    step(1, 5, 9, 1, 8, 64'h1234, 0, 0, "");
    idle_look(5, 5, "R7");
    step(0, 0, 0, 1, 9, 64'h5678, 0, 0, "");
    idle_look(5, 3, "R7");
    // R9 zero-tag broadcast ignored
    step(0, 0, 0, 1, 0, 64'hFFFF_FFFF, 0, 3, "R9");
    idle_look(0, 3, "R9");
    // R10 shared tag updates several registers
    step(1, 1, 3, 0, 0, 0, 0, 0, "");
    step(1, 2, 3, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 1, 3, 64'h0BAD_CAFE, 6, 6, "");
    idle_look(1, 2, "R10");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] rt;
      bit cv;
      rt = 4'($urandom_range(1, 15));
      cv = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 1) == 1) rt = m[4'($urandom_range(0, 15))];
      step($urandom_range(0, 1) == 1, 4'($urandom), 4'($urandom_range(1, 15)),
           cv, rt, {$urandom, $urandom}, 4'($urandom), 4'($urandom), "");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule